// File: doc/BRIEF.md
# Time-Division Audio Slot Bus Sequencer

The sequencer paces a shared time-division bus that carries 24-bit audio words between processing units. An external frame strobe, issued once per sample period, launches a pass over 64 time slots of four bus cycles each, 256 bus beats in all. The rate of that strobe sets the sample rate, typically 32, 44.1, 48 or 96 kHz. After the last beat the bus goes quiet and waits for the next strobe.

Slot ownership is fixed. The lowest eight slots belong to a router master. Each higher slot belongs to exactly one producer: slot `s` belongs to producer `s-8`. The owner of the current slot gets a grant and may present one word per bus cycle, so up to four words per slot. A registered broadcast stage publishes the word together with its slot and cycle index. Every consumer port watches for an address of its own and captures the matching word. Producers can therefore exchange data within the same frame.

Top module: `tdm_slot_seq`

## Requirements
- R1: While `rst_ni` is low and after it is released without a strobe, `bus_active_o`, `bus_valid_o`, `bus_data_o`, all grants, `cons_hit_o` and `cons_data_o` are zero.
- R2: A strobe sampled high at clock edge E makes the bus show slot 0, cycle 0 at edge E+1. The cycle index advances fastest and the slot index after cycle 3. There are exactly 256 beats with `bus_active_o` high.
- R3: After the beat at slot 63, cycle 3, and until the next strobe, `bus_active_o` and `bus_valid_o` are low and `bus_data_o` is zero, whatever the producers drive.
- R4: Slots 0 to 7 belong to the router master. `mst_grant_o` is high only in those slots, and the bus carries `mst_data_i` there when `mst_valid_i` is high.
- R5: Slot `s`, where 8 ≤ s ≤ 63, belongs only to producer `s-8`. Only `prod_grant_o[s-8]` is high, and the bus carries word `s-8` of `prod_data_i` (bits `(s-8)*24` upward).
- R6: When the owner of a beat does not assert its valid input, `bus_valid_o` is low and `bus_data_o` is zero for that beat, even if non-owners assert valid.
- R7: A strobe that arrives during a frame abandons that frame. The bus restarts at slot 0, cycle 0 one edge later and then runs a full 256-beat frame.
- R8: Consumer `c` has the address `cons_addr_i[c*8 +: 8]`, encoded as {slot[5:0], cycle[1:0]}. When a valid beat matches that address, `cons_hit_o[c]` pulses for one cycle on the following edge and `cons_data_o[c*24 +: 24]` takes that word.
- R9: A consumer whose addressed beat is not valid gets no hit, and its captured word keeps its previous value.
- R10: At most one grant is high at a time. All grants are zero while idle. A grant in one cycle is followed by an active bus beat on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame strobe, one cycle per sample period |
| mst_valid_i | input | 1 | Router master word valid |
| mst_data_i | input | 24 | Router master word |
| prod_valid_i | input | 56 | Per-producer word valid |
| prod_data_i | input | 1344 | Producer words, producer p at bits p*24 upward |
| cons_addr_i | input | 32 | Consumer capture addresses, {slot, cycle} per consumer |
| mst_grant_o | output | 1 | Router master owns the upcoming beat |
| prod_grant_o | output | 56 | One-hot producer grant for the upcoming beat |
| bus_active_o | output | 1 | Bus beat in progress |
| bus_slot_o | output | 6 | Slot index of the current beat |
| bus_cycle_o | output | 2 | Cycle index within the slot |
| bus_valid_o | output | 1 | Current beat carries a word |
| bus_data_o | output | 24 | Current bus word, zero when not valid |
| cons_hit_o | output | 4 | Per-consumer capture pulse |
| cons_data_o | output | 96 | Per-consumer captured words |

## Verification
A slot or cycle counter that is wrong shows up within one beat as a jump in the published index. The same fault also shows as a frame that ends after a number of beats other than 256. A wrong owner decode moves another port's word onto the bus in the very beat it occurs, and every slot is checked against its own owner. A capture comparator that is off by one shows as a missing or extra hit pulse one cycle after the beat, and as a stale or foreign captured word once the frame ends.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned SLOTS_DEF        = 64;
  localparam int unsigned CYCLES_DEF       = 4;
  localparam int unsigned WORD_W_DEF       = 24;
  localparam int unsigned MASTER_SLOTS_DEF = 8;
  localparam int unsigned CONS_DEF         = 4;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = SLOTS_DEF,
  parameter int unsigned CYCLES    = CYCLES_DEF,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  parameter int unsigned CYC_W     = $clog2(CYCLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CYC_W-1:0]  cyc_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(CYCLES - 1);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CYC_W-1:0]  cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
      cyc_q   <= '0;
    end else if (start_i) begin
      // a strobe always restarts, even mid-frame
      state_q <= SEQ_RUN;
      slot_q  <= '0;
      cyc_q   <= '0;
    end else if (state_q == SEQ_RUN) begin
      if (cyc_q == CYC_LAST) begin
        cyc_q <= '0;
        if (slot_q == SLOT_LAST) begin
          state_q <= SEQ_IDLE;
          slot_q  <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign active_o = (state_q == SEQ_RUN);
  assign slot_o   = slot_q;
  assign cyc_o    = cyc_q;
endmodule

// File: rtl/tdm_slot_owner_mux.sv
module tdm_slot_owner_mux #(
  parameter int unsigned MASTER_SLOTS = 8,
  parameter int unsigned NUM_PROD     = 56,
  parameter int unsigned DATA_W       = 24,
  parameter int unsigned SLOT_W       = 6
) (
  input  logic                       active_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic                       mst_valid_i,
  input  logic [DATA_W-1:0]          mst_data_i,
  input  logic [NUM_PROD-1:0]        prod_valid_i,
  input  logic [NUM_PROD*DATA_W-1:0] prod_data_i,
  output logic                       mst_grant_o,
  output logic [NUM_PROD-1:0]        prod_grant_o,
  output logic                       sel_valid_o,
  output logic [DATA_W-1:0]          sel_data_o
);
  assign mst_grant_o = active_i && (slot_i < SLOT_W'(MASTER_SLOTS));

  // hardwired ownership: producer p sits in slot MASTER_SLOTS+p
  for (genvar p = 0; p < NUM_PROD; p++) begin : g_grant
    assign prod_grant_o[p] = active_i && (slot_i == SLOT_W'(MASTER_SLOTS + p));
  end

  logic              own_valid;
  logic [DATA_W-1:0] own_data;

  always_comb begin
    own_valid = mst_grant_o & mst_valid_i;
    own_data  = mst_grant_o ? mst_data_i : '0;
    for (int p = 0; p < NUM_PROD; p++) begin
      if (prod_grant_o[p]) begin
        own_valid = own_valid | prod_valid_i[p];
        own_data  = own_data | prod_data_i[p*DATA_W +: DATA_W];
      end
    end
  end

  assign sel_valid_o = own_valid;
  assign sel_data_o  = own_valid ? own_data : '0;
endmodule

// File: rtl/tdm_slot_capture.sv
module tdm_slot_capture #(
  parameter int unsigned NUM_CONS = 4,
  parameter int unsigned POS_W    = 8,
  parameter int unsigned DATA_W   = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_active_i,
  input  logic [POS_W-1:0]           bus_pos_i,
  input  logic                       bus_valid_i,
  input  logic [DATA_W-1:0]          bus_data_i,
  input  logic [NUM_CONS*POS_W-1:0]  addr_i,
  output logic [NUM_CONS-1:0]        hit_o,
  output logic [NUM_CONS*DATA_W-1:0] data_o
);
  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic              hit_q;
    logic [DATA_W-1:0] word_q;
    logic              match;

    assign match = bus_active_i && bus_valid_i &&
                   (bus_pos_i == addr_i[c*POS_W +: POS_W]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q  <= 1'b0;
        word_q <= '0;
      end else begin
        hit_q <= match;
        if (match) word_q <= bus_data_i;
      end
    end

    assign hit_o[c]                  = hit_q;
    assign data_o[c*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_SLOTS    = SLOTS_DEF,
  parameter int unsigned CYCLES       = CYCLES_DEF,
  parameter int unsigned DATA_W       = WORD_W_DEF,
  parameter int unsigned MASTER_SLOTS = MASTER_SLOTS_DEF,
  parameter int unsigned NUM_CONS     = CONS_DEF,
  parameter int unsigned NUM_PROD     = NUM_SLOTS - MASTER_SLOTS,
  parameter int unsigned SLOT_W       = $clog2(NUM_SLOTS),
  parameter int unsigned CYC_W        = $clog2(CYCLES),
  parameter int unsigned POS_W        = SLOT_W + CYC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_start_i,
  input  logic                       mst_valid_i,
  input  logic [DATA_W-1:0]          mst_data_i,
  input  logic [NUM_PROD-1:0]        prod_valid_i,
  input  logic [NUM_PROD*DATA_W-1:0] prod_data_i,
  input  logic [NUM_CONS*POS_W-1:0]  cons_addr_i,
  output logic                       mst_grant_o,
  output logic [NUM_PROD-1:0]        prod_grant_o,
  output logic                       bus_active_o,
  output logic [SLOT_W-1:0]          bus_slot_o,
  output logic [CYC_W-1:0]           bus_cycle_o,
  output logic                       bus_valid_o,
  output logic [DATA_W-1:0]          bus_data_o,
  output logic [NUM_CONS-1:0]        cons_hit_o,
  output logic [NUM_CONS*DATA_W-1:0] cons_data_o
);
  logic              cnt_active;
  logic [SLOT_W-1:0] cnt_slot;
  logic [CYC_W-1:0]  cnt_cyc;
  logic              sel_valid;
  logic [DATA_W-1:0] sel_data;

  tdm_slot_counter #(
    .NUM_SLOTS(NUM_SLOTS), .CYCLES(CYCLES), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
  ) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (frame_start_i),
    .active_o(cnt_active),
    .slot_o  (cnt_slot),
    .cyc_o   (cnt_cyc)
  );

  tdm_slot_owner_mux #(
    .MASTER_SLOTS(MASTER_SLOTS), .NUM_PROD(NUM_PROD), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
  ) u_owner (
    .active_i    (cnt_active),
    .slot_i      (cnt_slot),
    .mst_valid_i (mst_valid_i),
    .mst_data_i  (mst_data_i),
    .prod_valid_i(prod_valid_i),
    .prod_data_i (prod_data_i),
    .mst_grant_o (mst_grant_o),
    .prod_grant_o(prod_grant_o),
    .sel_valid_o (sel_valid),
    .sel_data_o  (sel_data)
  );

  // broadcast stage: one register between owner and every consumer
  logic              bus_active_q;
  logic [SLOT_W-1:0] bus_slot_q;
  logic [CYC_W-1:0]  bus_cyc_q;
  logic              bus_valid_q;
  logic [DATA_W-1:0] bus_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_active_q <= 1'b0;
      bus_slot_q   <= '0;
      bus_cyc_q    <= '0;
      bus_valid_q  <= 1'b0;
      bus_data_q   <= '0;
    end else begin
      bus_active_q <= cnt_active;
      bus_slot_q   <= cnt_slot;
      bus_cyc_q    <= cnt_cyc;
      bus_valid_q  <= sel_valid;
      bus_data_q   <= sel_data;
    end
  end

  tdm_slot_capture #(
    .NUM_CONS(NUM_CONS), .POS_W(POS_W), .DATA_W(DATA_W)
  ) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_active_i(bus_active_q),
    .bus_pos_i   ({bus_slot_q, bus_cyc_q}),
    .bus_valid_i (bus_valid_q),
    .bus_data_i  (bus_data_q),
    .addr_i      (cons_addr_i),
    .hit_o       (cons_hit_o),
    .data_o      (cons_data_o)
  );

  assign bus_active_o = bus_active_q;
  assign bus_slot_o   = bus_slot_q;
  assign bus_cycle_o  = bus_cyc_q;
  assign bus_valid_o  = bus_valid_q;
  assign bus_data_o   = bus_data_q;
endmodule

// File: rtl/tdm_slot_seq_chk.sv
module tdm_slot_seq_chk #(
  parameter int unsigned MASTER_SLOTS = 8,
  parameter int unsigned NUM_PROD     = 56,
  parameter int unsigned NUM_CONS     = 4,
  parameter int unsigned DATA_W       = 24,
  parameter int unsigned SLOT_W       = 6,
  parameter int unsigned CYC_W        = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mst_grant_i,
  input logic [NUM_PROD-1:0] prod_grant_i,
  input logic                bus_active_i,
  input logic [SLOT_W-1:0]   bus_slot_i,
  input logic [CYC_W-1:0]    bus_cycle_i,
  input logic                bus_valid_i,
  input logic [DATA_W-1:0]   bus_data_i,
  input logic [NUM_CONS-1:0] cons_hit_i
);
  logic [SLOT_W+CYC_W-1:0] pos;
  assign pos = {bus_slot_i, bus_cycle_i};

  a_r2_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_active_i && pos != '0) |-> ($past(bus_active_i) && pos == $past(pos) + 1'b1));

  a_r2_entry_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_active_i) |-> (pos == '0));

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_active_i |-> (!bus_valid_i && bus_data_i == '0));

  a_r6_zero_when_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |-> (bus_data_i == '0));

  a_r4_master_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_active_i && bus_slot_i < SLOT_W'(MASTER_SLOTS)) |-> $past(mst_grant_i));

  a_r10_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mst_grant_i, prod_grant_i}));

  a_r10_grant_leads_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_grant_i || (|prod_grant_i)) |=> bus_active_i);

  a_r8_hit_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cons_hit_i) |-> $past(bus_valid_i && bus_active_i));
endmodule

bind tdm_slot_seq tdm_slot_seq_chk #(
  .MASTER_SLOTS(MASTER_SLOTS), .NUM_PROD(NUM_PROD), .NUM_CONS(NUM_CONS),
  .DATA_W(DATA_W), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mst_grant_i (mst_grant_o),
  .prod_grant_i(prod_grant_o),
  .bus_active_i(bus_active_o),
  .bus_slot_i  (bus_slot_o),
  .bus_cycle_i (bus_cycle_o),
  .bus_valid_i (bus_valid_o),
  .bus_data_i  (bus_data_o),
  .cons_hit_i  (cons_hit_o)
);

// File: tb/tdm_slot_seq_bench.sv
module tdm_slot_seq_bench;
  localparam int NS = 64, NC = 4, DW = 24, MS = 8, NP = NS - MS, NCONS = 4, PW = 8;
  localparam int BEATS = NS * NC;

  logic clk = 1'b0, rst_ni = 1'b0, frame_start = 1'b0;
  logic mst_v = 1'b0;
  logic [DW-1:0] mst_d = '0;
  logic [NP-1:0] prod_v = '0;
  logic [NP*DW-1:0] prod_d = '0;
  logic [NCONS*PW-1:0] caddr = '0;
  logic mst_g, bus_act, bus_v;
  logic [NP-1:0] prod_g;
  logic [5:0] bus_slot;
  logic [1:0] bus_cyc;
  logic [DW-1:0] bus_d;
  logic [NCONS-1:0] c_hit;
  logic [NCONS*DW-1:0] c_data;

  int n_chk = 0, n_fail = 0;
  int hits [NCONS];
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdm_slot_seq u_tdm_slot_seq (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start),
    .mst_valid_i(mst_v), .mst_data_i(mst_d), .prod_valid_i(prod_v), .prod_data_i(prod_d),
    .cons_addr_i(caddr), .mst_grant_o(mst_g), .prod_grant_o(prod_g),
    .bus_active_o(bus_act), .bus_slot_o(bus_slot), .bus_cycle_o(bus_cyc),
    .bus_valid_o(bus_v), .bus_data_o(bus_d), .cons_hit_o(c_hit), .cons_data_o(c_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pword(int p, int seed);
    return {8'(seed), 8'(p), 8'hC3};
  endfunction

  task automatic load(input int seed, input bit mv, input logic [NP-1:0] pv);
    mst_v  = mv;
    mst_d  = {8'(seed), 8'hFF, 8'h3C};
    prod_v = pv;
    for (int p = 0; p < NP; p++) prod_d[p*DW +: DW] = pword(p, seed);
  endtask

  function automatic bit exp_valid(int slot);
    return (slot < MS) ? mst_v : prod_v[slot-MS];
  endfunction

  function automatic logic [DW-1:0] exp_word(int slot);
    if (!exp_valid(slot)) return '0;
    return (slot < MS) ? mst_d : prod_d[(slot-MS)*DW +: DW];
  endfunction

  task automatic start_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic count_hits();
    for (int c = 0; c < NCONS; c++) hits[c] += int'(c_hit[c]);
  endtask

  // checks nb beats; a full frame also checks the idle beat after it
  task automatic walk(input int nb);
    for (int c = 0; c < NCONS; c++) hits[c] = 0;
    for (int k = 0; k < nb; k++) begin
      int s = k / NC;
      logic [NP-1:0] eg = '0;
      if (s >= MS) eg[s-MS] = 1'b1;
      chk("R4 master grant", 64'(mst_g), 64'(s < MS));
      chk("R5 producer grant", 64'(prod_g), 64'(eg));
      @(negedge clk);
      count_hits();
      chk("R2 active", 64'(bus_act), 64'd1);
      chk("R2 slot", 64'(bus_slot), 64'(s));
      chk("R2 cycle", 64'(bus_cyc), 64'(k % NC));
      chk("R6 valid", 64'(bus_v), 64'(exp_valid(s)));
      chk("R5 data", 64'(bus_d), 64'(exp_word(s)));
    end
    if (nb == BEATS) begin
      chk("R10 grants idle", 64'({mst_g, prod_g}), 64'd0);
      @(negedge clk);
      count_hits();
      chk("R3 active after frame", 64'(bus_act), 64'd0);
      chk("R3 valid after frame", 64'(bus_v), 64'd0);
      chk("R3 data after frame", 64'(bus_d), 64'd0);
    end
  endtask

  task automatic chk_cons(input int c, input int slot, input int exp_hits, input logic [DW-1:0] exp_d);
    chk($sformatf("R8 hits c%0d", c), 64'(hits[c]), 64'(exp_hits));
    chk($sformatf("R8 word c%0d", c), 64'(c_data[c*DW +: DW]), 64'(exp_d));
    if (slot < 0) chk("R9 unused", 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 active", 64'(bus_act), 64'd0);
    chk("R1 valid", 64'(bus_v), 64'd0);
    chk("R1 data", 64'(bus_d), 64'd0);
    chk("R1 grants", 64'({mst_g, prod_g}), 64'd0);
    chk("R1 hits", 64'(c_hit), 64'd0);
    chk("R1 captured", 64'(c_data), 64'd0);
  endtask

  task automatic t_full();
    logic [DW-1:0] w0, w1, w2, w3;
    load(1, 1'b1, '1);
    caddr = {8'h16, 8'hFF, 8'h21, 8'h00}; // c0 {0,0} c1 {8,1} c2 {63,3} c3 {5,2}
    w0 = exp_word(0); w1 = exp_word(8); w2 = exp_word(63); w3 = exp_word(5);
    start_frame();
    walk(BEATS);
    chk_cons(0, 0, 1, w0);
    chk_cons(1, 8, 1, w1);
    chk_cons(2, 63, 1, w2);
    chk_cons(3, 5, 1, w3);
  endtask

  task automatic t_sparse();
    logic [NP-1:0] odd = '0;
    logic [DW-1:0] old0, old2;
    for (int p = 1; p < NP; p += 2) odd[p] = 1'b1;
    old0 = c_data[0 +: DW];
    old2 = c_data[2*DW +: DW];
    load(2, 1'b0, odd);
    caddr = {8'hFF, 8'h2A, 8'h24, 8'h0D}; // c0 {3,1} c1 {9,0} c2 {10,2} c3 {63,3}
    start_frame();
    walk(BEATS);
    // R9: invalid addressed beats give no hit and keep the old word
    chk("R9 hits c0", 64'(hits[0]), 64'd0);
    chk("R9 word c0", 64'(c_data[0 +: DW]), 64'(old0));
    chk("R9 hits c2", 64'(hits[2]), 64'd0);
    chk("R9 word c2", 64'(c_data[2*DW +: DW]), 64'(old2));
    chk_cons(1, 9, 1, pword(1, 2));
    chk_cons(3, 63, 1, pword(55, 2));
  endtask

  task automatic t_idle();
    load(4, 1'b1, '1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R3 idle active", 64'(bus_act), 64'd0);
      chk("R3 idle valid", 64'(bus_v), 64'd0);
      chk("R3 idle data", 64'(bus_d), 64'd0);
      chk("R10 idle grants", 64'({mst_g, prod_g}), 64'd0);
      chk("R3 idle hits", 64'(c_hit), 64'd0);
    end
  endtask

  task automatic t_restart();
    load(3, 1'b1, '1);
    caddr = {8'h00, 8'h00, 8'h00, 8'h00};
    start_frame();
    walk(37);
    start_frame();
    walk(BEATS);
    chk("R7 restart hit", 64'(hits[0]), 64'd1);
    chk("R7 restart word", 64'(c_data[0 +: DW]), 64'(mst_d));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_sparse();
    t_idle();
    t_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule